// File: doc/BRIEF.md
# Copy Request Splitter with Per-Request Residue

This block sits in front of a single memory-copy engine whose length field is only `CW` bits wide. Each copy request has a source address, a destination address, a 64-bit byte count and a tag. The block cuts every request into chunks no longer than the engine's largest length, `M = 2^CW - 1`. It generates the chunks one per cycle into a first-in, first-out queue. It hands them to the engine one at a time through a start/done handshake.

Each accepted request takes one parent slot. The slot holds the tag and a residue counter. The residue starts at the full byte count. Each finished chunk subtracts its own length from it. When the residue reaches zero, the block emits a single-cycle completion pulse with the tag and frees the slot. A combinational query port returns the current residue of any tag that is still in progress.

Top module: `xfer_splitter`

## Requirements
- R1: A request of length L is issued to the engine as ceil(L / M) chunks, where M = 2^CW - 1. Every chunk except the final one has length M, and the final chunk carries the remainder.
- R2: The source and destination of chunk k each equal the request's source and destination plus k*M, which is the sum of the lengths of the earlier chunks.
- R3: From the cycle after acceptance, a residue query with the request's tag returns the full request length until the first chunk of that request finishes.
- R4: Each `eng_done` subtracts the finished chunk's length from its parent's residue. `cpl_valid` pulses for exactly one cycle, carrying the parent tag on `cpl_tag`, in the cycle after the done that brings that residue to zero, and never earlier.
- R5: Chunks reach the engine in the order they were generated, including across different requests. At most one chunk is in flight at any time. When the queue is not empty, `eng_start` rises in the cycle right after an `eng_done`.
- R6: A residue query for a tag that has completed, or that was never accepted, returns zero.
- R7: A request of length zero is accepted but ignored. It starts no chunk, raises no completion and takes no parent slot.
- R8: `req_ready` is low while a request is still being split and while all NP parent slots are busy. Splitting pauses while the queue holds QD chunks.
- R9: After reset, `req_ready` is 1, and `eng_start`, `cpl_valid` and `qry_residue` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_src | input | AW | Request source address |
| req_dst | input | AW | Request destination address |
| req_len | input | LW | Request byte count |
| req_tag | input | TW | Request tag |
| eng_start | output | 1 | Start the head chunk on the engine |
| eng_src | output | AW | Head chunk source |
| eng_dst | output | AW | Head chunk destination |
| eng_len | output | CW | Head chunk length |
| eng_done | input | 1 | Engine finished the chunk in flight |
| cpl_valid | output | 1 | One-cycle parent completion pulse |
| cpl_tag | output | TW | Tag of the completed parent |
| qry_tag | input | TW | Tag to look up |
| qry_residue | output | LW | Residue of the queried tag, 0 if not in progress |

## Verification
The split is swept over lengths just below, at and just above one and several multiples of M. These separate an off-by-one in the chunk count, in the length of the last chunk and in the address step. A single request with the engine paused chunk by chunk shows the residue stepping down, and confirms that no completion appears until the residue is zero. Several requests queued behind a stalled engine distinguish FIFO ordering across parents from per-parent completion. Filling every slot, and sending one request with more chunks than the queue holds, exercise both backpressure paths. A zero-length request shows that it is ignored.

// File: rtl/xfer_splitter.sv
module xfer_splitter #(
  parameter int AW = 64,
  parameter int LW = 64,
  parameter int TW = 4,
  parameter int CW = 28,
  parameter int QD = 8,
  parameter int NP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_src,
  input  logic [AW-1:0] req_dst,
  input  logic [LW-1:0] req_len,
  input  logic [TW-1:0] req_tag,
  output logic          eng_start,
  output logic [AW-1:0] eng_src,
  output logic [AW-1:0] eng_dst,
  output logic [CW-1:0] eng_len,
  input  logic          eng_done,
  output logic          cpl_valid,
  output logic [TW-1:0] cpl_tag,
  input  logic [TW-1:0] qry_tag,
  output logic [LW-1:0] qry_residue
);
  localparam int QAW = (QD > 1) ? $clog2(QD) : 1;
  localparam int PW  = (NP > 1) ? $clog2(NP) : 1;
  localparam logic [LW-1:0] MAXL = {{(LW-CW){1'b0}}, {CW{1'b1}}};
  localparam logic [QAW:0] QFULL = (QAW+1)'(QD);

  logic [AW-1:0] q_src [QD];
  logic [AW-1:0] q_dst [QD];
  logic [CW-1:0] q_len [QD];
  logic [PW-1:0] q_slot[QD];
  logic [QAW-1:0] wr_ptr, rd_ptr;
  logic [QAW:0]   q_cnt;

  logic          s_vld [NP];
  logic [TW-1:0] s_tag [NP];
  logic [LW-1:0] s_res [NP];

  logic          sp_act;
  logic [AW-1:0] sp_src, sp_dst;
  logic [LW-1:0] sp_rem;
  logic [PW-1:0] sp_slot;

  logic          busy;
  logic          free_any;
  logic [PW-1:0] free_idx;
  logic          push, pop, accept, last;
  logic [CW-1:0] ch_len;
  logic [PW-1:0] hs;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = NP-1; i >= 0; i--)
      if (!s_vld[i]) begin
        free_any = 1'b1;
        free_idx = PW'(i);
      end
  end

  always_comb begin
    qry_residue = '0;
    for (int i = NP-1; i >= 0; i--)
      if (s_vld[i] && s_tag[i] == qry_tag) qry_residue = s_res[i];
  end

  assign req_ready = !sp_act && free_any;
  assign accept    = req_valid && req_ready;
  assign last      = sp_rem <= MAXL;
  assign ch_len    = last ? sp_rem[CW-1:0] : MAXL[CW-1:0];
  assign push      = sp_act && (q_cnt != QFULL);
  assign pop       = eng_done && busy;
  assign hs        = q_slot[rd_ptr];

  assign eng_start = (q_cnt != '0) && !busy;
  assign eng_src   = q_src[rd_ptr];
  assign eng_dst   = q_dst[rd_ptr];
  assign eng_len   = q_len[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_act  <= 1'b0;
      sp_src  <= '0;
      sp_dst  <= '0;
      sp_rem  <= '0;
      sp_slot <= '0;
    end else if (accept && req_len != '0) begin
      sp_act  <= 1'b1;
      sp_src  <= req_src;
      sp_dst  <= req_dst;
      sp_rem  <= req_len;
      sp_slot <= free_idx;
    end else if (push) begin
      sp_act <= !last;
      sp_src <= sp_src + AW'(ch_len);
      sp_dst <= sp_dst + AW'(ch_len);
      sp_rem <= sp_rem - LW'(ch_len);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      q_src[wr_ptr]  <= sp_src;
      q_dst[wr_ptr]  <= sp_dst;
      q_len[wr_ptr]  <= ch_len;
      q_slot[wr_ptr] <= sp_slot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      q_cnt  <= '0;
      busy   <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == QAW'(QD-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == QAW'(QD-1)) ? '0 : rd_ptr + 1'b1;
      q_cnt <= q_cnt + (QAW+1)'(push) - (QAW+1)'(pop);
      if (eng_start)  busy <= 1'b1;
      else if (pop)   busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpl_valid <= 1'b0;
      cpl_tag   <= '0;
      for (int i = 0; i < NP; i++) begin
        s_vld[i] <= 1'b0;
        s_tag[i] <= '0;
        s_res[i] <= '0;
      end
    end else begin
      cpl_valid <= 1'b0;
      if (accept && req_len != '0) begin
        s_vld[free_idx] <= 1'b1;
        s_tag[free_idx] <= req_tag;
        s_res[free_idx] <= req_len;
      end
      if (pop) begin
        s_res[hs] <= s_res[hs] - LW'(q_len[rd_ptr]);
        if (s_res[hs] == LW'(q_len[rd_ptr])) begin
          s_vld[hs] <= 1'b0;
          cpl_valid <= 1'b1;
          cpl_tag   <= s_tag[hs];
        end
      end
    end
  end
endmodule

module xfer_splitter_chk #(
  parameter int LW = 64,
  parameter int CW = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [LW-1:0] req_len,
  input logic          eng_start,
  input logic [CW-1:0] eng_len,
  input logic          cpl_valid
);
  assert_single_flight_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  assert_chunk_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_len != '0);
  assert_split_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_len != '0) |=> !req_ready);
  assert_cpl_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !cpl_valid);
endmodule

bind xfer_splitter xfer_splitter_chk #(.LW(LW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .eng_start(eng_start), .eng_len(eng_len),
  .cpl_valid(cpl_valid)
);

// File: tb/xfer_splitter_tb.sv
module xfer_splitter_tb;
  localparam int AW = 64, LW = 64, TW = 4, CW = 28, QD = 8, NP = 4;
  localparam longint M = (64'd1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_src = '0, req_dst = '0;
  logic [LW-1:0] req_len = '0;
  logic [TW-1:0] req_tag = '0;
  logic eng_start;
  logic [AW-1:0] eng_src, eng_dst;
  logic [CW-1:0] eng_len;
  logic eng_done = 1'b0;
  logic cpl_valid;
  logic [TW-1:0] cpl_tag;
  logic [TW-1:0] qry_tag = '0;
  logic [LW-1:0] qry_residue;

  always #4 clk = ~clk;

  xfer_splitter #(.AW(AW), .LW(LW), .TW(TW), .CW(CW), .QD(QD), .NP(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .req_len(req_len), .req_tag(req_tag),
    .eng_start(eng_start), .eng_src(eng_src), .eng_dst(eng_dst), .eng_len(eng_len),
    .eng_done(eng_done), .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
    .qry_tag(qry_tag), .qry_residue(qry_residue));

  int errors = 0, checks = 0;
  longint st_src[256], st_dst[256], st_len[256];
  int st_cyc[256], dn_cyc[256];
  int cp_tag[64], cp_dn[64];
  int n_st = 0, n_done = 0, n_cpl = 0, cyc = 0;
  bit pend = 0, hold = 0, trace_on = 0;
  int credit = 0, cnt = 0, lat = 2;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial forever begin
    @(negedge clk);
    cyc++;
    eng_done = 1'b0;
    if (trace_on) begin
      if (cpl_valid) begin
        cp_tag[n_cpl] = int'(cpl_tag);
        cp_dn[n_cpl] = n_done;
        n_cpl++;
      end
      if (pend && (!hold || credit > 0)) begin
        if (cnt == 0) begin
          eng_done = 1'b1;
          pend = 0;
          dn_cyc[n_done] = cyc;
          n_done++;
          if (hold) credit--;
        end else cnt--;
      end
      if (eng_start && !pend) begin
        st_src[n_st] = longint'(eng_src);
        st_dst[n_st] = longint'(eng_dst);
        st_len[n_st] = longint'(eng_len);
        st_cyc[n_st] = cyc;
        n_st++;
        pend = 1;
        cnt = lat;
      end
    end
  end

  task automatic send(input int tag, input longint src, input longint dst, input longint len);
    @(negedge clk);
    req_valid = 1'b1;
    req_tag = TW'(tag);
    req_src = src;
    req_dst = dst;
    req_len = len;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic query(input int tag, output longint r);
    qry_tag = TW'(tag);
    #1;
    r = longint'(qry_residue);
  endtask

  task automatic wait_cpl(input int target);
    while (n_cpl < target) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_chunks(input int base, input longint src, input longint dst,
                              input longint len, input int n);
    for (int k = 0; k < n; k++) begin
      longint el;
      el = (k == n-1) ? len - longint'(k) * M : M;
      chk(st_len[base+k] == el, "R1", "chunk length", st_len[base+k], el);
      chk(st_src[base+k] == src + longint'(k) * M, "R2", "chunk source",
          st_src[base+k], src + longint'(k) * M);
      chk(st_dst[base+k] == dst + longint'(k) * M, "R2", "chunk destination",
          st_dst[base+k], dst + longint'(k) * M);
    end
  endtask

  initial begin
    longint r;
    longint lens[7];
    lens = '{1, M-1, M, M+1, 2*M, 2*M+1, 3*M+7};
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);
    chk(eng_start == 1'b0, "R9", "start after reset", eng_start, 0);
    chk(cpl_valid == 1'b0, "R9", "cpl after reset", cpl_valid, 0);
    query(0, r);
    chk(r == 0, "R9", "query after reset", r, 0);
    rst_n = 1'b1;
    trace_on = 1;
    @(negedge clk);

    // R1 R2 R4 R6: length sweep around multiples of M
    for (int i = 0; i < 7; i++) begin
      int b, d, c, n;
      longint s, t;
      b = n_st; d = n_done; c = n_cpl;
      n = int'((lens[i] + M - 1) / M);
      s = 64'h1_0000_0000 + longint'(i) * 64'h10_0000_0000 + i;
      t = 64'h2000_0000_0000 + longint'(i) * 3;
      send(i + 1, s, t, lens[i]);
      wait_cpl(c + 1);
      chk(n_st - b == n, "R1", "chunk count", n_st - b, n);
      check_chunks(b, s, t, lens[i], n);
      chk(cp_tag[c] == i + 1, "R4", "completion tag", cp_tag[c], i + 1);
      chk(cp_dn[c] == d + n, "R4", "completion after last chunk", cp_dn[c] - d, n);
      query(i + 1, r);
      chk(r == 0, "R6", "residue after completion", r, 0);
    end
    query(15, r);
    chk(r == 0, "R6", "unknown tag residue", r, 0);

    // R3 R4: residue steps with the engine paused
    begin
      int c, d;
      c = n_cpl; d = n_done;
      hold = 1; credit = 0;
      send(5, 64'h4000, 64'h8000, 2*M + 5);
      repeat (8) @(negedge clk);
      query(5, r);
      chk(r == 2*M + 5, "R3", "initial residue", r, 2*M + 5);
      credit = 1;
      while (n_done < d + 1) @(negedge clk);
      repeat (4) @(negedge clk);
      query(5, r);
      chk(r == M + 5, "R4", "residue after one chunk", r, M + 5);
      credit = 1;
      while (n_done < d + 2) @(negedge clk);
      repeat (4) @(negedge clk);
      query(5, r);
      chk(r == 5, "R4", "residue after two chunks", r, 5);
      chk(n_cpl == c, "R4", "no early completion", n_cpl - c, 0);
      hold = 0;
      wait_cpl(c + 1);
      chk(cp_tag[c] == 5, "R4", "completion tag", cp_tag[c], 5);
      query(5, r);
      chk(r == 0, "R6", "residue after completion", r, 0);
    end

    // R7: zero length ignored
    begin
      int b, c;
      b = n_st; c = n_cpl;
      send(3, 64'h100, 64'h200, 0);
      repeat (10) @(negedge clk);
      chk(n_st == b, "R7", "no chunk for zero length", n_st - b, 0);
      chk(n_cpl == c, "R7", "no completion for zero length", n_cpl - c, 0);
      query(3, r);
      chk(r == 0, "R7", "no slot for zero length", r, 0);
      chk(req_ready == 1'b1, "R7", "ready after zero length", req_ready, 1);
    end

    // R5: FIFO across parents, restart the cycle after done
    begin
      int b, c, d;
      b = n_st; c = n_cpl; d = n_done;
      hold = 1; credit = 0;
      send(1, 64'h10000, 64'h90000, M + 1);
      send(2, 64'h20000, 64'hA0000, 5);
      send(3, 64'h30000, 64'hB0000, 2*M);
      repeat (10) @(negedge clk);
      hold = 0;
      wait_cpl(c + 3);
      chk(n_st - b == 5, "R5", "total chunks", n_st - b, 5);
      check_chunks(b, 64'h10000, 64'h90000, M + 1, 2);
      check_chunks(b + 2, 64'h20000, 64'hA0000, 5, 1);
      check_chunks(b + 3, 64'h30000, 64'hB0000, 2*M, 2);
      chk(cp_tag[c] == 1 && cp_tag[c+1] == 2 && cp_tag[c+2] == 3, "R5",
          "completion order", cp_tag[c]*100 + cp_tag[c+1]*10 + cp_tag[c+2], 123);
      chk(cp_dn[c] - d == 2 && cp_dn[c+1] - d == 3 && cp_dn[c+2] - d == 5, "R4",
          "completion points", (cp_dn[c]-d)*100 + (cp_dn[c+1]-d)*10 + cp_dn[c+2]-d, 235);
      for (int k = 1; k < 5; k++)
        chk(st_cyc[b+k] == dn_cyc[d+k-1] + 1, "R5", "restart gap",
            st_cyc[b+k] - dn_cyc[d+k-1], 1);
    end

    // R8: all slots busy, then queue full
    begin
      int b, c;
      c = n_cpl;
      hold = 1; credit = 0;
      for (int t = 8; t < 12; t++) send(t, 64'h1000 * t, 64'h2000 * t, 1);
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b0, "R8", "ready with slots full", req_ready, 0);
      hold = 0;
      wait_cpl(c + 4);
      chk(req_ready == 1'b1, "R8", "ready after slots free", req_ready, 1);
      b = n_st; c = n_cpl;
      hold = 1;
      send(12, 64'h5_0000_0000, 64'h7_0000_0000, 10*M);
      repeat (20) @(negedge clk);
      chk(n_st - b == 1, "R5", "one chunk in flight", n_st - b, 1);
      chk(req_ready == 1'b0, "R8", "ready while split stalled", req_ready, 0);
      query(12, r);
      chk(r == 10*M, "R3", "residue of long request", r, 10*M);
      hold = 0;
      wait_cpl(c + 1);
      chk(n_st - b == 10, "R8", "all chunks after stall", n_st - b, 10);
      check_chunks(b, 64'h5_0000_0000, 64'h7_0000_0000, 10*M, 10);
      chk(cp_tag[c] == 12, "R4", "long request tag", cp_tag[c], 12);
    end

    finish_run();
  end
endmodule